// File: doc/BRIEF.md
# GPIO Interrupt Router

This block takes the interrupt requests of three GPIO banks of 32 lines each and turns them into a 41-bit interrupt vector for a platform interrupt controller. Each line's request is first gated by that line's own enable bit. A 32-bit select register then decides, for each of the first 32 vector positions, where the position's line comes from. It is either a line from bank 0 or bank 1 (select bit 0) or the same-index line from bank 2 (select bit 1). Six more positions carry fixed bank 1 lines.

Some lines have no dedicated position. These are OR-reduced into one aggregate output per bank, placed at the top three positions of the vector. Flipping a select bit moves a line between its dedicated position and its bank's aggregate output, so every enabled request always reaches exactly one output.

Firmware writes the select register once through a simple write port, before interrupts are in use. The register value can be read back. All 41 outputs leave the block from flops.

Top module: `gpio_irq_router`

## Requirements
- R1: Output k for k in 0..13 carries bank 0 line k when select bit k is 0, and bank 2 line k when select bit k is 1.
- R2: Output k for k in 14..31 carries bank 1 line k-14 when select bit k is 0, and bank 2 line k when select bit k is 1.
- R3: Outputs 32..37 always carry bank 1 lines 18..23, whatever the select register holds.
- R4: Output 38 is the OR of the enabled bank 0 requests on lines 14..31, plus those on lines i<14 whose select bit i is 1.
- R5: Output 39 is the OR of the enabled bank 1 requests on lines 24..31, plus those on lines j<18 whose select bit j+14 is 1.
- R6: Output 40 is the OR of the enabled bank 2 requests on lines i whose select bit i is 0.
- R7: A line whose enable bit is 0 drives no output, whatever its pending flag.
- R8: While reset is high, the select register and all 41 outputs are cleared to zero on each clock edge.
- R9: Every output reflects the pending flags, enables and select value that were present at the previous rising clock edge.
- R10: With the write strobe high at a clock edge, the select register takes the write data. Without the strobe it holds its value, and its value is visible on the readback port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pend0_i | input | 32 | Bank 0 per-line pending flags |
| pend1_i | input | 32 | Bank 1 per-line pending flags |
| pend2_i | input | 32 | Bank 2 per-line pending flags |
| en0_i | input | 32 | Bank 0 per-line interrupt enables |
| en1_i | input | 32 | Bank 1 per-line interrupt enables |
| en2_i | input | 32 | Bank 2 per-line interrupt enables |
| sel_we_i | input | 1 | Select register write strobe |
| sel_wdata_i | input | 32 | Select register write data |
| sel_q_o | output | 32 | Select register readback |
| irq_o | output | 41 | Registered interrupt vector |

## Verification
The bench targets the boundary indices where the source bank changes: bits 13 and 14 of the select register, and bank 1 lines 17, 18, 23 and 24. A router with an off-by-one index there would send a line to the wrong output, or duplicate it, or drop it. It also swaps single lines and checks that each one leaves its dedicated output and shows up on its bank's aggregate output. A design whose aggregate masks did not follow the select bits would either lose the request or raise it twice. Pending flags are driven with enables off to catch missing gating. A long run with changing inputs and changing select values compares every cycle against a model with one cycle of delay, which exposes an extra or a missing register stage.

// File: rtl/gir_pkg.sv
package gir_pkg;
  localparam int GIR_BANKS = 3;

  // Width of the interrupt vector for a given line count and direct counts.
  function automatic int gir_n_out(input int lines, input int b0_dir, input int b1_dir);
    return lines + (b1_dir - (lines - b0_dir)) + GIR_BANKS;
  endfunction
endpackage

// File: rtl/gir_sel_reg.sv
module gir_sel_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/gir_gate.sv
module gir_gate #(
  parameter int W = 32
) (
  input  logic [W-1:0] pend,
  input  logic [W-1:0] en,
  output logic [W-1:0] act
);
  assign act = pend & en;
endmodule

// File: rtl/gir_route.sv
module gir_route #(
  parameter int LINES  = 32,
  parameter int B0_DIR = 14,
  parameter int B1_DIR = 24,
  parameter int N_OUT  = gir_pkg::gir_n_out(LINES, B0_DIR, B1_DIR)
) (
  input  logic [LINES-1:0] act0,
  input  logic [LINES-1:0] act1,
  input  logic [LINES-1:0] act2,
  input  logic [LINES-1:0] sel,
  output logic [N_OUT-1:0] nxt
);
  localparam int B1_SWAP  = LINES - B0_DIR;
  localparam int B1_FIXED = B1_DIR - B1_SWAP;
  localparam int AGG0     = LINES + B1_FIXED;

  // mask bit set = line owns a dedicated output now
  logic [LINES-1:0] own0, own1, own2;

  for (genvar k = 0; k < LINES; k++) begin : g_sel
    if (k < B0_DIR) begin : g_b0
      assign nxt[k]  = sel[k] ? act2[k] : act0[k];
      assign own0[k] = ~sel[k];
    end else begin : g_b1
      assign nxt[k]  = sel[k] ? act2[k] : act1[k-B0_DIR];
      assign own0[k] = 1'b0;
    end
  end

  for (genvar f = 0; f < B1_FIXED; f++) begin : g_fix
    assign nxt[LINES+f] = act1[B1_SWAP+f];
  end

  for (genvar j = 0; j < LINES; j++) begin : g_own1
    if (j < B1_SWAP) begin : g_sw
      assign own1[j] = ~sel[j+B0_DIR];
    end else if (j < B1_DIR) begin : g_fx
      assign own1[j] = 1'b1;
    end else begin : g_ag
      assign own1[j] = 1'b0;
    end
  end

  assign own2 = sel;

  assign nxt[AGG0]   = |(act0 & ~own0);
  assign nxt[AGG0+1] = |(act1 & ~own1);
  assign nxt[AGG0+2] = |(act2 & ~own2);
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router #(
  parameter int LINES  = 32,
  parameter int B0_DIR = 14,
  parameter int B1_DIR = 24,
  localparam int N_OUT = gir_pkg::gir_n_out(LINES, B0_DIR, B1_DIR)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] pend0_i,
  input  logic [LINES-1:0] pend1_i,
  input  logic [LINES-1:0] pend2_i,
  input  logic [LINES-1:0] en0_i,
  input  logic [LINES-1:0] en1_i,
  input  logic [LINES-1:0] en2_i,
  input  logic             sel_we_i,
  input  logic [LINES-1:0] sel_wdata_i,
  output logic [LINES-1:0] sel_q_o,
  output logic [N_OUT-1:0] irq_o
);
  logic [gir_pkg::GIR_BANKS-1:0][LINES-1:0] pend_a, en_a, act_a;
  logic [N_OUT-1:0] irq_nxt;

  assign pend_a = {pend2_i, pend1_i, pend0_i};
  assign en_a   = {en2_i, en1_i, en0_i};

  for (genvar b = 0; b < gir_pkg::GIR_BANKS; b++) begin : g_bank
    gir_gate #(.W(LINES)) u_gate (
      .pend (pend_a[b]),
      .en   (en_a[b]),
      .act  (act_a[b])
    );
  end

  gir_sel_reg #(.W(LINES)) u_sel (
    .clk   (clk),
    .rst   (rst),
    .we    (sel_we_i),
    .wdata (sel_wdata_i),
    .q     (sel_q_o)
  );

  gir_route #(.LINES(LINES), .B0_DIR(B0_DIR), .B1_DIR(B1_DIR), .N_OUT(N_OUT)) u_route (
    .act0 (act_a[0]),
    .act1 (act_a[1]),
    .act2 (act_a[2]),
    .sel  (sel_q_o),
    .nxt  (irq_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_o <= '0;
    else     irq_o <= irq_nxt;
  end
endmodule

// File: rtl/gir_chk.sv
module gir_chk #(
  parameter int LINES = 32,
  parameter int N_OUT = 41
) (
  input logic             clk,
  input logic             rst,
  input logic [LINES-1:0] pend0_i,
  input logic [LINES-1:0] pend1_i,
  input logic [LINES-1:0] pend2_i,
  input logic [LINES-1:0] en0_i,
  input logic [LINES-1:0] en1_i,
  input logic [LINES-1:0] en2_i,
  input logic             sel_we_i,
  input logic [LINES-1:0] sel_wdata_i,
  input logic [LINES-1:0] sel_q_o,
  input logic [N_OUT-1:0] irq_o
);
  // R8
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (irq_o == '0 && sel_q_o == '0));

  // R3
  fixed_outs_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> irq_o[37:32] == $past(pend1_i[23:18] & en1_i[23:18]));

  // R7
  all_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(en0_i == '0 && en1_i == '0 && en2_i == '0)) |-> irq_o == '0);

  // R10
  sel_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sel_we_i)) |-> sel_q_o == $past(sel_wdata_i));

  // R10
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sel_we_i)) |-> $stable(sel_q_o));

  // R6
  bank2_agg_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sel_q_o) == '0) |-> irq_o[40] == |$past(pend2_i & en2_i));

  // R1
  all_bank2_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sel_q_o) == '1) |-> irq_o[31:0] == $past(pend2_i & en2_i));
endmodule

bind gpio_irq_router gir_chk #(.LINES(LINES), .N_OUT(N_OUT)) u_gir_chk (
  .clk (clk), .rst (rst),
  .pend0_i (pend0_i), .pend1_i (pend1_i), .pend2_i (pend2_i),
  .en0_i (en0_i), .en1_i (en1_i), .en2_i (en2_i),
  .sel_we_i (sel_we_i), .sel_wdata_i (sel_wdata_i),
  .sel_q_o (sel_q_o), .irq_o (irq_o)
);

// File: tb/gpio_irq_router_bench.sv
module gpio_irq_router_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] p0 = '0, p1 = '0, p2 = '0;
  logic [31:0] e0 = '0, e1 = '0, e2 = '0;
  logic        we = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] sel_q;
  logic [40:0] irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  gpio_irq_router u_gpio_irq_router (
    .clk (clk), .rst (rst),
    .pend0_i (p0), .pend1_i (p1), .pend2_i (p2),
    .en0_i (e0), .en1_i (e1), .en2_i (e2),
    .sel_we_i (we), .sel_wdata_i (wd),
    .sel_q_o (sel_q), .irq_o (irq)
  );

  function automatic logic [40:0] model(input logic [31:0] a0, a1, a2, s);
    logic [40:0] r;
    r = '0;
    for (int k = 0; k < 32; k++) begin
      if (s[k])        r[k] = a2[k];
      else if (k < 14) r[k] = a0[k];
      else             r[k] = a1[k-14];
    end
    for (int f = 0; f < 6; f++) r[32+f] = a1[18+f];
    for (int i = 0; i < 32; i++) begin
      if (a0[i] && (i >= 14 || s[i]))                        r[38] = 1'b1;
      if (a1[i] && (i >= 24 || (i < 18 && s[i+14])))        r[39] = 1'b1;
      if (a2[i] && !s[i])                                    r[40] = 1'b1;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [40:0] act, input logic [40:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, one rising edge, sample at following negedge
  task automatic apply(input logic [31:0] a0, a1, a2);
    p0 = a0; p1 = a1; p2 = a2;
    @(negedge clk);
  endtask

  task automatic wr_sel(input logic [31:0] v);
    we = 1'b1; wd = v;
    @(negedge clk);
    we = 1'b0; wd = ~v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R8 irq", irq, '0);
    chk("R8 sel", {9'd0, sel_q}, '0);
  endtask

  task automatic t_default();
    e0 = '1; e1 = '1; e2 = '1;
    apply(32'h1 << 3, 0, 0);   chk("R1 b0 line3", irq, 41'h1 << 3);
    apply(32'h1 << 13, 0, 0);  chk("R1 b0 line13", irq, 41'h1 << 13);
    apply(32'h1 << 14, 0, 0);  chk("R4 b0 line14", irq, 41'h1 << 38);
    apply(32'h1 << 20, 0, 0);  chk("R4 b0 line20", irq, 41'h1 << 38);
    apply(0, 32'h1 << 0, 0);   chk("R2 b1 line0", irq, 41'h1 << 14);
    apply(0, 32'h1 << 17, 0);  chk("R2 b1 line17", irq, 41'h1 << 31);
    apply(0, 32'h1 << 18, 0);  chk("R3 b1 line18", irq, 41'h1 << 32);
    apply(0, 32'h1 << 23, 0);  chk("R3 b1 line23", irq, 41'h1 << 37);
    apply(0, 32'h1 << 24, 0);  chk("R5 b1 line24", irq, 41'h1 << 39);
    apply(0, 0, 32'h1 << 7);   chk("R6 b2 line7", irq, 41'h1 << 40);
    apply(0, 0, 0);
  endtask

  task automatic t_swap();
    wr_sel(32'h0000_6008);   // bits 3, 13, 14
    chk("R10 sel write", {9'd0, sel_q}, {9'd0, 32'h0000_6008});
    apply(32'h1 << 3, 0, 0);  chk("R4 swapped b0 line3", irq, 41'h1 << 38);
    apply(0, 0, 32'h1 << 3);  chk("R1 b2 line3", irq, 41'h1 << 3);
    apply(0, 0, 32'h1 << 13); chk("R1 b2 line13", irq, 41'h1 << 13);
    apply(0, 32'h1, 0);       chk("R5 swapped b1 line0", irq, 41'h1 << 39);
    apply(0, 0, 32'h1 << 14); chk("R2 b2 line14", irq, 41'h1 << 14);
    apply(0, 0, 32'h1 << 5);  chk("R6 b2 line5 agg", irq, 41'h1 << 40);
    apply(0, 32'h1 << 20, 0); chk("R3 fixed under swap", irq, 41'h1 << 34);
    we = 1'b0; wd = 32'hFFFF_FFFF;
    @(negedge clk);
    chk("R10 sel hold", {9'd0, sel_q}, {9'd0, 32'h0000_6008});
    apply(0, 0, 0);
  endtask

  task automatic t_enable();
    e0 = '0; e1 = '0; e2 = '0;
    apply('1, '1, '1); chk("R7 all disabled", irq, '0);
    e1 = 32'h1 << 20;
    @(negedge clk);    chk("R7 one enabled", irq, 41'h1 << 34);
    e0 = '1; e1 = '1; e2 = '1;
    apply(0, 0, 0);
  endtask

  task automatic t_latency();
    p0 = 32'h1; #1;
    chk("R9 not before edge", irq, '0);
    @(negedge clk);
    chk("R9 after one edge", irq, model(p0 & e0, p1 & e1, p2 & e2, sel_q));
    apply(0, 0, 0);
  endtask

  task automatic t_random();
    logic [31:0] lfsr = 32'hACE1_2345;
    logic [31:0] s_m;
    logic [40:0] exp;
    s_m = sel_q;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      p0 = lfsr & {lfsr[15:0], lfsr[31:16]};
      p1 = lfsr ^ {lfsr[7:0], lfsr[31:8]};
      p2 = ~lfsr & {lfsr[3:0], lfsr[31:4]};
      p0 = (n % 3 == 0) ? (32'h1 << (n % 32)) : p0;
      e0 = (n % 5 == 0) ? ~lfsr : '1;
      e1 = (n % 7 == 0) ? {lfsr[23:0], lfsr[31:24]} : '1;
      e2 = '1;
      we = (n % 9 == 0);
      wd = {lfsr[11:0], lfsr[31:12]};
      exp = model(p0 & e0, p1 & e1, p2 & e2, s_m);
      if (we) s_m = wd;
      @(negedge clk);
      chk("R1 R2 R3 R4 R5 R6 R9 random", irq, exp);
      chk("R10 random sel", {9'd0, sel_q}, {9'd0, s_m});
    end
    we = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_default();
    t_swap();
    t_enable();
    t_latency();
    t_random();
    rst = 1'b1;
    @(negedge clk);
    t_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule